// File: doc/BRIEF.md
# Randomized Wait Interval Timer

This block produces a wait whose length cannot be guessed in advance, for use in a reaction-time game where a player must not be able to anticipate the moment of the stimulus. An 8-bit counter runs freely on every system clock. When a requester asks for a wait, the current counter value is taken as the wait length. Because the request comes from a human action that has no relation to the clock, the sampled value is effectively random.

A value below the minimum is raised to the minimum, so the wait is never too short. The result is loaded into a down-counter that steps once per coarse tick. The coarse tick comes from a prescaler whose period is a parameter given in clock cycles. With a 40 ms tick, the wait lies between about 2.5 and 10.2 seconds.

The block has a single output, a flag that is high while the down-counter is zero. The flag also serves as the load acknowledge in a level handshake. The requester raises start and holds it until the flag drops. The flag then rises again when the wait has run out.

Top module: `rand_wait_timer`

## Requirements
- R1: After reset the wait counter is zero, so `expired_o` reads 1, and it stays 1 while `start_i` stays low.
- R2: The sample counter counts up by one on every clock from 0 after reset and wraps from 255 to 0. The value sampled at a load is the number of clocks since reset, modulo 256, at that edge.
- R3: A tick occurs on every TICK_CYCLES-th clock edge after reset, that is, on edge k (counting from 0) when k mod TICK_CYCLES = TICK_CYCLES-1. `start_i` is acted on only at a tick: a start that is high only between ticks leaves `expired_o` at 1.
- R4: At a tick with `start_i` = 1 and the wait counter at zero, the counter is loaded with max(sample, MIN_LOAD), where MIN_LOAD defaults to 63. `expired_o` is 0 from the following cycle.
- R5: Once loaded with V, the counter decrements by one at each tick and then holds at zero. `expired_o` is therefore 0 for exactly V×TICK_CYCLES cycles and then returns to 1.
- R6: `start_i` has no effect while the wait counter is nonzero. Raising or toggling it during a wait neither reloads nor lengthens the wait.
- R7: If `start_i` is still high when the counter reaches zero, a new wait is loaded at the next tick, so `expired_o` is 1 for exactly TICK_CYCLES cycles between the two waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Wait request level, held by the requester until `expired_o` falls |
| expired_o | output | 1 | High while no wait is running; acts as load acknowledge when it falls |

## Verification
The bench builds the block with TICK_CYCLES = 4 and leaves the 8-bit sample width and MIN_LOAD = 63 at their defaults. The longest wait is then 1020 cycles, so the shortest and longest waits, the clamp at 63, the value just above it and wraparound samples can all be reached in a few thousand cycles. The short tick also makes both kinds of ignored start easy to place on exact edges: starts that fall between ticks, and starts that arrive during a running wait.

// File: rtl/rand_wait_timer.sv
module rand_wait_timer #(
  parameter int CNT_W       = 8,
  parameter int MIN_LOAD    = 63,
  parameter int TICK_CYCLES = 4_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);
  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [CNT_W-1:0]  free_cnt;
  logic [CNT_W-1:0]  wait_cnt;
  logic [TICK_W-1:0] pre_cnt;
  logic              tick;
  logic [CNT_W-1:0]  load_val;

  assign tick      = (pre_cnt == TICK_W'(TICK_CYCLES - 1));
  assign load_val  = (free_cnt < CNT_W'(MIN_LOAD)) ? CNT_W'(MIN_LOAD) : free_cnt;
  assign expired_o = (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_cnt <= '0;
    else        free_cnt <= free_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (tick) begin
      if (expired_o && start_i) wait_cnt <= load_val;
      else if (!expired_o)      wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rand_wait_timer_chk.sv
module rand_wait_timer_chk #(
  parameter int CNT_W       = 8,
  parameter int MIN_LOAD    = 63,
  parameter int TICK_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             expired_o,
  input logic             tick,
  input logic [CNT_W-1:0] wait_cnt
);
  AST_LOAD_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expired_o) |-> ($past(tick) && $past(start_i))); // R3

  AST_CLAMP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wait_cnt == '0 && start_i) |=> (wait_cnt >= CNT_W'(MIN_LOAD))); // R4

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && wait_cnt != '0) |=> $stable(wait_cnt)); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wait_cnt != '0) |=> (wait_cnt == $past(wait_cnt) - 1'b1)); // R6

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !start_i) |=> expired_o); // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_CYCLES > 1 && tick) |=> !tick); // R3
endmodule

bind rand_wait_timer rand_wait_timer_chk #(
  .CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD), .TICK_CYCLES(TICK_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .expired_o(expired_o),
  .tick(tick), .wait_cnt(wait_cnt)
);

// File: tb/rand_wait_timer_tb_top.sv
module rand_wait_timer_tb_top;
  localparam int T   = 4;
  localparam int MIN = 63;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic expired_o;
  int   vec = 0, bad = 0;
  int   mcyc = 0, mdown = 0;
  bit   in_reset = 1;
  string req = "R1";

  always #5 clk = ~clk;

  rand_wait_timer #(.CNT_W(8), .MIN_LOAD(MIN), .TICK_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .expired_o(expired_o)
  );

  // behavioural reference: cycle count since reset drives sample and tick
  always @(posedge clk) begin
    if (!rst_n) begin
      mcyc = 0; mdown = 0;
    end else begin
      if (mcyc % T == T - 1) begin
        if (mdown == 0 && start_i) mdown = ((mcyc % 256) < MIN) ? MIN : (mcyc % 256);
        else if (mdown > 0) mdown = mdown - 1;
      end
      mcyc = mcyc + 1;
    end
  end

  task automatic check(input string r, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", r, act, exp, mcyc);
    end
  endtask

  always @(negedge clk) if (!in_reset) check(req, expired_o, (mdown == 0) ? 1 : 0);

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  function automatic int next_at(input int m);
    int t = mcyc + 1;
    while (t % 256 != m) t++;
    return t;
  endfunction

  // raise start so that the next edge is edge 'target'; count the low cycles
  task automatic run_wait(input int target, input bit keep, output int low);
    while (mcyc != target) @(negedge clk);
    start_i = 1;
    @(negedge clk);
    low = 0;
    while (!expired_o) begin
      low++;
      if (!keep) start_i = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    int low, hi, tgt, exp;
    repeat (3) @(negedge clk);
    check("R1", expired_o, 1);
    rst_n = 1;
    in_reset = 0;
    repeat (20) @(negedge clk);
    check("R1", expired_o, 1);

    req = "R3";
    while (mcyc % T != 1) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (2 * T) @(negedge clk);
    check("R3", expired_o, 1);

    req = "R4";
    tgt = next_at(7);
    run_wait(tgt, 0, low);
    check("R4", low, MIN * T);

    tgt = next_at(67);
    run_wait(tgt, 0, low);
    check("R2", low, 67 * T);

    tgt = next_at(63);
    run_wait(tgt, 0, low);
    check("R4", low, 63 * T);

    req = "R5";
    tgt = next_at(255);
    run_wait(tgt, 0, low);
    check("R5", low, 255 * T);
    repeat (3 * T) @(negedge clk);
    check("R5", expired_o, 1);

    req = "R6";
    tgt = next_at(203);
    while (mcyc != tgt) @(negedge clk);
    start_i = 1; @(negedge clk);
    low = 0;
    while (!expired_o) begin
      low++;
      start_i = (low % 7 == 3);
      @(negedge clk);
    end
    start_i = 0;
    check("R6", low, 203 * T);

    req = "R7";
    repeat (T) @(negedge clk);
    tgt = next_at(99);
    run_wait(tgt, 1, low);
    check("R7", low, 99 * T);
    hi = 0;
    while (expired_o) begin hi++; @(negedge clk); end
    check("R7", hi, T);
    exp = (tgt + 99 * T + T) % 256;
    if (exp < MIN) exp = MIN;
    start_i = 0;
    low = 1;
    @(negedge clk);
    while (!expired_o) begin low++; @(negedge clk); end
    check("R7", low, exp * T);
    repeat (2 * T) @(negedge clk);
    check("R1", expired_o, 1);
    finish_up();
  end
endmodule